// File: doc/BRIEF.md
# Converter Output Reset and Soft-Mute Sequencer

This block sits between the resampling core of an audio sample-rate converter and its serial output. It decides when converter samples may reach the output pin. It holds the output at zero while the converter is powered down, while the clock-recovery loop and rate detector settle, and for a one-cycle internal reset after any clock change. It also scales passed samples by a gain that ramps down to silence or back to unity when soft mute is requested.

The controller is built around four states. POWERDOWN is entered from any state when the power-down pin is low or the power-enable bit is 0. In this state the filter reset is held and the bidirectional data pin is driven low as an output. POWERDOWN moves to WAIT_LOCK once both are released. WAIT_LOCK moves to RUN when lock/rate detection reports done, or when a timeout of `LOCK_TMO` output word strobes runs out. From POWERDOWN, WAIT_LOCK, RUN or CLKCHG_RESET, an input-side or output-side clock-change pulse, when there is no power-down request, moves the block to CLKCHG_RESET. CLKCHG_RESET holds the filter reset for one cycle and then moves to WAIT_LOCK. Only RUN passes data.

The gain is a value from 0 to 2^`RAMP_BITS`. In RUN it steps by one on each output word strobe, toward zero while soft mute is requested and toward full scale otherwise. The sample is multiplied by this gain, divided by 2^`RAMP_BITS` and truncated toward zero.

Top module: `src_out_sequencer`

## Requirements
- R1: While `pd_n` is low, from the cycle after the sampling edge onward, `out_sample` is 0, `filt_rst` is 1 and `sdio_oe` is 1 (POWERDOWN).
- R2: `pwr_en` = 0 has the same effect as `pd_n` low, with identical output values.
- R3: After release, `out_sample` stays 0 in WAIT_LOCK. After an edge that samples `lock_done` = 1 in WAIT_LOCK, the block is in RUN, and at full gain `out_sample` equals `raw_sample`.
- R4: A one-cycle pulse on `clk_chg_in` or `clk_chg_out` without power-down leads to one cycle of CLKCHG_RESET (`filt_rst` = 1, `out_sample` = 0, `sdio_oe` = 0), then WAIT_LOCK with zero output until lock again.
- R5: In WAIT_LOCK without `lock_done`, the edge that samples the `LOCK_TMO`-th `word_stb` of that wait moves the block to RUN. Strobes need not be consecutive.
- R6: In RUN with `smute_req` = 1, the gain drops by 1 on each edge that samples `word_stb` = 1, down to 0. Full mute is reached after 2^`RAMP_BITS` (1024) strobes, and the gain is steady between strobes.
- R7: In RUN with `smute_req` = 0, the gain rises by 1 per sampled strobe up to 2^`RAMP_BITS`, where the output equals the input again.
- R8: `sdio_oe` is 1 only in POWERDOWN. From the cycle after a release it is 0.
- R9: `smute_req` = 1 sampled in WAIT_LOCK or CLKCHG_RESET clears the gain at once, so RUN begins with zero output. In POWERDOWN the gain is loaded with 0 if mute is requested, and with full scale otherwise.
- R10: `out_sample` = trunc-toward-zero(`raw_sample` × gain / 2^`RAMP_BITS`), so a negative sample never rounds away from zero.
- R11: A power-down request takes priority over a clock change and over `lock_done` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset to POWERDOWN |
| pd_n | input | 1 | Power-down pin, active low |
| pwr_en | input | 1 | Power-enable register bit, 0 = power down |
| clk_chg_in | input | 1 | Pulse: input-side clock changed |
| clk_chg_out | input | 1 | Pulse: output-side clock changed |
| lock_done | input | 1 | Lock and rate detection finished |
| smute_req | input | 1 | Soft-mute request level |
| word_stb | input | 1 | One pulse per output sample period |
| raw_sample | input | DATA_W | Signed converter sample |
| out_sample | output | DATA_W | Gated, gain-scaled signed sample |
| filt_rst | output | 1 | Filter reset, high in POWERDOWN and CLKCHG_RESET |
| sdio_oe | output | 1 | Output enable of the bidirectional data pin |

## Verification
State and gain change only at a clock edge. `out_sample`, `filt_rst` and `sdio_oe` follow combinationally from them and from the current `raw_sample`. The effect of a control input sampled at an edge is therefore due in the cycle that starts at that edge, while a new sample value is due in the same cycle it is applied. The driver changes inputs just after a rising edge and pushes the expectation for that same cycle. The monitor pops it at the falling edge, so every compare falls half a period after the state update and half a period before the next one.

// File: rtl/src_seq_pkg.sv
package src_seq_pkg;

    typedef enum logic [1:0] {
        ST_POWERDOWN    = 2'd0,
        ST_WAIT_LOCK    = 2'd1,
        ST_RUN          = 2'd2,
        ST_CLKCHG_RESET = 2'd3
    } seq_state_t;

endpackage

// File: rtl/seq_ctrl_fsm.sv
module seq_ctrl_fsm
    import src_seq_pkg::*;
#(
    parameter int LOCK_TMO = 4800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_n,
    input  logic       pwr_en,
    input  logic       clk_chg_in,
    input  logic       clk_chg_out,
    input  logic       lock_done,
    input  logic       word_stb,
    output seq_state_t st,
    output logic       filt_rst,
    output logic       sdio_oe,
    output logic       run
);

    localparam int            TW       = $clog2(LOCK_TMO + 1);
    localparam logic [TW-1:0] TMO_LAST = TW'(LOCK_TMO - 1);

    seq_state_t    st_nxt;
    logic [TW-1:0] tmo_cnt;
    logic          pd_req;
    logic          chg;

    assign pd_req = !pd_n || !pwr_en;
    assign chg    = clk_chg_in || clk_chg_out;

    // next-state decision: power-down first, then clock change
    always_comb begin
        st_nxt = st;
        if (pd_req) begin
            st_nxt = ST_POWERDOWN;
        end else if (chg) begin
            st_nxt = ST_CLKCHG_RESET;
        end else begin
            unique case (st)
                ST_POWERDOWN:    st_nxt = ST_WAIT_LOCK;
                ST_WAIT_LOCK: begin
                    if (lock_done)
                        st_nxt = ST_RUN;
                    else if (word_stb && tmo_cnt == TMO_LAST)
                        st_nxt = ST_RUN;
                end
                ST_RUN:          st_nxt = ST_RUN;
                ST_CLKCHG_RESET: st_nxt = ST_WAIT_LOCK;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_POWERDOWN;
        else
            st <= st_nxt;
    end

    // lock timeout, counted in output word strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tmo_cnt <= '0;
        else if (st != ST_WAIT_LOCK)
            tmo_cnt <= '0;
        else if (word_stb)
            tmo_cnt <= tmo_cnt + 1'b1;
    end

    // state-decoded outputs
    always_comb begin
        filt_rst = 1'b0;
        sdio_oe  = 1'b0;
        run      = 1'b0;
        unique case (st)
            ST_POWERDOWN: begin
                filt_rst = 1'b1;
                sdio_oe  = 1'b1;
            end
            ST_WAIT_LOCK:    ;
            ST_RUN:          run = 1'b1;
            ST_CLKCHG_RESET: filt_rst = 1'b1;
        endcase
    end

endmodule

// File: rtl/seq_gain_ramp.sv
module seq_gain_ramp
    import src_seq_pkg::*;
#(
    parameter int RAMP_BITS = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  seq_state_t           st,
    input  logic                 smute_req,
    input  logic                 word_stb,
    output logic [RAMP_BITS:0]   gain
);

    localparam int              GW   = RAMP_BITS + 1;
    localparam logic [GW-1:0]   FULL = GW'(1) << RAMP_BITS;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain <= FULL;
        end else begin
            unique case (st)
                ST_POWERDOWN:
                    gain <= smute_req ? '0 : FULL;
                ST_WAIT_LOCK, ST_CLKCHG_RESET:
                    if (smute_req) gain <= '0;
                ST_RUN:
                    if (word_stb) begin
                        if (smute_req && gain != '0)
                            gain <= gain - 1'b1;
                        else if (!smute_req && gain != FULL)
                            gain <= gain + 1'b1;
                    end
            endcase
        end
    end

endmodule

// File: rtl/seq_gain_apply.sv
module seq_gain_apply #(
    parameter int DATA_W    = 24,
    parameter int RAMP_BITS = 10
) (
    input  logic signed [DATA_W-1:0] din,
    input  logic        [RAMP_BITS:0] gain,
    input  logic                      pass,
    output logic signed [DATA_W-1:0] dout
);

    localparam int PW = DATA_W + RAMP_BITS + 2;
    localparam int SH = RAMP_BITS;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] bias;
    logic signed [PW-1:0] biased;
    logic signed [PW-1:0] shifted;

    always_comb begin
        prod    = PW'(din) * $signed({1'b0, gain});
        // add 2^SH-1 to negative products so the shift truncates toward zero
        bias    = $signed({{(PW-SH){1'b0}}, {SH{prod[PW-1]}}});
        biased  = prod + bias;
        shifted = biased >>> SH;
        dout    = pass ? shifted[DATA_W-1:0] : '0;
    end

endmodule

// File: rtl/src_out_sequencer.sv
module src_out_sequencer
    import src_seq_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int RAMP_BITS = 10,
    parameter int LOCK_TMO  = 4800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_n,
    input  logic              pwr_en,
    input  logic              clk_chg_in,
    input  logic              clk_chg_out,
    input  logic              lock_done,
    input  logic              smute_req,
    input  logic              word_stb,
    input  logic [DATA_W-1:0] raw_sample,
    output logic [DATA_W-1:0] out_sample,
    output logic              filt_rst,
    output logic              sdio_oe
);

    seq_state_t         st_w;
    logic               run_w;
    logic [RAMP_BITS:0] gain_w;
    logic signed [DATA_W-1:0] scaled_w;

    seq_ctrl_fsm #(
        .LOCK_TMO (LOCK_TMO)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd_n        (pd_n),
        .pwr_en      (pwr_en),
        .clk_chg_in  (clk_chg_in),
        .clk_chg_out (clk_chg_out),
        .lock_done   (lock_done),
        .word_stb    (word_stb),
        .st          (st_w),
        .filt_rst    (filt_rst),
        .sdio_oe     (sdio_oe),
        .run         (run_w)
    );

    seq_gain_ramp #(
        .RAMP_BITS (RAMP_BITS)
    ) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .st        (st_w),
        .smute_req (smute_req),
        .word_stb  (word_stb),
        .gain      (gain_w)
    );

    seq_gain_apply #(
        .DATA_W    (DATA_W),
        .RAMP_BITS (RAMP_BITS)
    ) u_apply (
        .din  ($signed(raw_sample)),
        .gain (gain_w),
        .pass (run_w),
        .dout (scaled_w)
    );

    assign out_sample = scaled_w;

endmodule

// File: rtl/src_out_sequencer_chk.sv
module src_out_sequencer_chk
    import src_seq_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int RAMP_BITS = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pd_n,
    input logic               pwr_en,
    input logic               clk_chg_in,
    input logic               clk_chg_out,
    input logic               lock_done,
    input logic               smute_req,
    input logic               word_stb,
    input logic [DATA_W-1:0]  out_sample,
    input logic               filt_rst,
    input logic               sdio_oe,
    input seq_state_t         st,
    input logic [RAMP_BITS:0] gain
);

    localparam logic [RAMP_BITS:0] FULL = (RAMP_BITS+1)'(1) << RAMP_BITS;

    logic chg;
    assign chg = clk_chg_in || clk_chg_out;

    AST_PD_FORCES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (out_sample == '0 && filt_rst && sdio_oe)); // R1

    AST_PWREN_FORCES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && !pwr_en) |=> (out_sample == '0 && filt_rst && sdio_oe)); // R2

    AST_LOCK_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && pwr_en && !chg && st == ST_WAIT_LOCK && lock_done) |=> st == ST_RUN); // R3

    AST_CLKCHG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && pwr_en && chg) |=> (filt_rst && !sdio_oe && out_sample == '0)); // R4

    AST_RAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !word_stb) |=> $stable(gain)); // R6

    AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && word_stb && smute_req && gain != '0) |=> gain == $past(gain) - 1'b1); // R6

    AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        gain <= FULL); // R7

    AST_RELEASE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && pwr_en) |=> !sdio_oe); // R8

    AST_MUTE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_WAIT_LOCK || st == ST_CLKCHG_RESET) && smute_req) |=> gain == '0); // R9

endmodule

bind src_out_sequencer src_out_sequencer_chk #(
    .DATA_W    (DATA_W),
    .RAMP_BITS (RAMP_BITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pd_n        (pd_n),
    .pwr_en      (pwr_en),
    .clk_chg_in  (clk_chg_in),
    .clk_chg_out (clk_chg_out),
    .lock_done   (lock_done),
    .smute_req   (smute_req),
    .word_stb    (word_stb),
    .out_sample  (out_sample),
    .filt_rst    (filt_rst),
    .sdio_oe     (sdio_oe),
    .st          (st_w),
    .gain        (gain_w)
);

// File: tb/test_src_out_sequencer.sv
`timescale 1ns/1ps
module test_src_out_sequencer;

    localparam int DW   = 24;
    localparam int RB   = 10;
    localparam int TMO  = 20;
    localparam int FULL = 1 << RB;

    logic clk = 1'b0;
    logic rst_n, pd_n, pwr_en, ci, co, lock, smute, stb;
    logic signed [DW-1:0] raw;
    logic [DW-1:0] dout;
    logic frst, oe;

    always #4 clk = ~clk;   // 125 MHz

    src_out_sequencer #(
        .DATA_W    (DW),
        .RAMP_BITS (RB),
        .LOCK_TMO  (TMO)
    ) i_src_out_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd_n        (pd_n),
        .pwr_en      (pwr_en),
        .clk_chg_in  (ci),
        .clk_chg_out (co),
        .lock_done   (lock),
        .smute_req   (smute),
        .word_stb    (stb),
        .raw_sample  (raw),
        .out_sample  (dout),
        .filt_rst    (frst),
        .sdio_oe     (oe)
    );

    typedef struct {
        string         tag;
        logic [DW-1:0] out;
        logic          frst;
        logic          oe;
    } exp_t;

    typedef enum {M_PD, M_WAIT, M_RUN, M_CHG} mst_t;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;
    mst_t m     = M_PD;
    int   mg    = FULL;
    int   mcnt  = 0;

    function automatic logic [DW-1:0] scale(logic signed [DW-1:0] x, int g);
        longint p = longint'(x) * longint'(g);
        longint r = p / longint'(FULL);   // integer division truncates toward zero
        return r[DW-1:0];
    endfunction

    // driver: push expectation for this cycle, then advance the model
    task automatic step(input string tag);
        exp_t e;
        mst_t nm;
        int   nc;
        e.tag  = tag;
        e.oe   = (m == M_PD);
        e.frst = (m == M_PD) || (m == M_CHG);
        e.out  = (m == M_RUN) ? scale(raw, mg) : '0;
        q.push_back(e);

        nm = m;
        if (!pd_n || !pwr_en)   nm = M_PD;
        else if (ci || co)      nm = M_CHG;
        else case (m)
            M_PD:   nm = M_WAIT;
            M_WAIT: if (lock || (stb && mcnt == TMO - 1)) nm = M_RUN;
            M_RUN:  nm = M_RUN;
            M_CHG:  nm = M_WAIT;
        endcase
        nc = (m != M_WAIT) ? 0 : (stb ? mcnt + 1 : mcnt);
        case (m)
            M_PD:         mg = smute ? 0 : FULL;
            M_WAIT, M_CHG: if (smute) mg = 0;
            M_RUN: if (stb) begin
                if (smute && mg > 0)          mg = mg - 1;
                else if (!smute && mg < FULL) mg = mg + 1;
            end
        endcase
        m    = nm;
        mcnt = nc;
        @(posedge clk);
        #1;
    endtask

    // monitor
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (dout !== e.out || frst !== e.frst || oe !== e.oe) begin
                bad++;
                $display("FAIL %s: out=%h exp=%h filt_rst=%b exp=%b oe=%b exp=%b",
                         e.tag, dout, e.out, frst, e.frst, oe, e.oe);
            end
        end
    end

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; pd_n = 0; pwr_en = 1; ci = 0; co = 0;
        lock = 0; smute = 0; stb = 0; raw = 24'sd1000;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;

        // R1: held in power-down
        repeat (3) step("R1");
        raw = -24'sd777;
        step("R1");

        // R8 / R3: release, wait for lock with zero output
        pd_n = 1;
        step("R8");
        raw = 24'sd12345;
        repeat (4) step("R3");
        lock = 1; step("R3"); lock = 0;
        step("R3");
        raw = -24'sd5000;   step("R10");
        raw = 24'sh7FFFFF;  step("R3");
        raw = -24'sh800000; step("R3");

        // R2: register bit power-down
        pwr_en = 0; step("R2"); step("R2");
        pwr_en = 1; step("R2");
        lock = 1; step("R3"); lock = 0;
        step("R3");

        // R4: clock changes on both sides
        ci = 1; step("R4"); ci = 0;
        step("R4"); step("R4");
        co = 1; step("R4"); co = 0;
        step("R4");
        lock = 1; step("R4"); lock = 0;
        step("R4");

        // R5: timeout with every-cycle strobes, then sparse strobes
        ci = 1; step("R5"); ci = 0;
        stb = 1;
        repeat (TMO + 3) step("R5");
        stb = 0;
        co = 1; step("R5"); co = 0;
        for (int i = 0; i < 3 * TMO + 2; i++) begin
            stb = (i % 3 == 0);
            step("R5");
        end
        stb = 0;

        // R6 / R10: mute ramp on a negative sample
        raw = -24'sd3001; smute = 1; stb = 1;
        repeat (500) step("R6");
        repeat (530) step("R10");
        stb = 0;
        repeat (3) step("R6");

        // R7: unmute ramp back to unity
        smute = 0; raw = 24'sd4095; stb = 1;
        repeat (1030) step("R7");
        stb = 0;

        // R9: mute requested during a clock-change reset
        smute = 1; ci = 1; step("R9"); ci = 0;
        step("R9");
        lock = 1; step("R9"); lock = 0;
        raw = 24'sd9999; stb = 1;
        repeat (4) step("R9");
        smute = 0;
        repeat (4) step("R7");
        stb = 0;

        // R11: power-down wins over clock change and lock
        pd_n = 0; ci = 1; lock = 1; step("R11");
        ci = 0; lock = 0; step("R11");
        pd_n = 1; step("R11");
        lock = 1; step("R11"); lock = 0;
        step("R11");

        @(negedge clk);
        #1;
        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R1: scoreboard left %0d exp 0", q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule